// File: doc/BRIEF.md
# Interrupt Flag and Enable Register

This block holds four event interrupt flags, each paired with its own enable bit, in one host-accessible register. It drives a single active-low interrupt line. Hardware raises a flag with a single-cycle pulse on one of four event inputs:

- a system bus error;
- a wake from sleep;
- an excessive transmit deferral;
- the reception of a magic packet.

The host reads the register at any time. A write clears the flags through write-one-to-clear and loads the enable bits directly.

Each source has its own reset domain. A hard reset clears everything. A soft reset clears only part of the register. A stop command clears only the magic-packet flag. The sleep-wake and deferral sources survive a soft reset, so the wake source can still raise an interrupt after the global interrupt enable has been lost. For that reason these two sources bypass the global enable. The system-error and magic-packet sources need the global enable.

The register layout is as follows:

| Bits | Contents |
|------|----------|
| 0 and 1 | System-error flag and enable |
| 2 and 3 | Wake flag and enable |
| 4 and 5 | Deferral flag and enable |
| 6 and 7 | Magic-packet flag and enable |
| 8 | Read-only summary bit |

Top module: `irqc_top`

## Requirements
- R1: A one-cycle pulse on an event input sets its flag at the next rising clock edge. If a host write of one to that flag bit lands in the same cycle, the flag still ends at one.
- R2: A host write with a one in a flag bit (bit 2i for source i) clears that flag at the next edge. A zero in that bit leaves the flag unchanged.
- R3: A host write loads each enable bit (bit 2i+1) from the written data at the next edge. The enable and flag bits read back on rd_data in the layout given above.
- R4: While hard_rst_n is low, every flag and enable reads zero and irq_n is high.
- R5: A soft reset pulse clears the flags and enables of the system-error source (i=0) and the magic-packet source (i=3). It leaves the wake source (i=1) and the deferral source (i=2) unchanged.
- R6: A stop pulse clears only the magic-packet flag. Every enable and every other flag is left unchanged.
- R7: When the wake or deferral flag is set together with its own enable, irq_n is low, whatever global_ie holds.
- R8: The system-error and magic-packet sources drive irq_n low only when the flag, its own enable and global_ie are all one.
- R9: rd_data bit 8 reads one exactly when some flag is set together with its own enable. This bit is not gated by global_ie.
- R10: A soft reset or stop that clears a flag takes priority over a same-cycle event for that flag. A flag outside that clear's domain is still set by its event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| stop_cmd | input | 1 | Synchronous stop command pulse |
| ev_pulse | input | 4 | Event pulses: 0 system error, 1 wake, 2 deferral, 3 magic packet |
| global_ie | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 9 | Host write data (bit 8 ignored) |
| rd_data | output | 9 | Register read value |
| irq_n | output | 1 | Combined interrupt, active low |

## Verification
Every flag and enable change is registered, so it shows on rd_data one rising edge after the stimulus. Stimulus is driven at the falling edge and results are sampled at the following falling edge. irq_n and the summary bit are combinational from the registers and global_ie. They are checked in the same half-cycle as rd_data. A toggle of global_ie alone is checked half a cycle later, with no edge in between. A sweep over all flag, enable and global-enable combinations compares each result against an arithmetic model of the gating. Directed cases cover clearing and the same-cycle collisions.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC  = 4;
  localparam int REG_W = 2 * NSRC + 1;

  localparam int SRC_SYSERR = 0;
  localparam int SRC_WAKE   = 1;
  localparam int SRC_DEFER  = 2;
  localparam int SRC_MAGIC  = 3;

  typedef struct packed {
    logic flag_soft;  // flag cleared by soft reset
    logic flag_stop;  // flag cleared by stop command
    logic en_soft;    // enable cleared by soft reset
    logic need_gie;   // interrupt gated by the global enable
  } dom_t;

  function automatic dom_t src_domain(input int i);
    dom_t d;
    case (i)
      SRC_SYSERR: d = '{flag_soft: 1'b1, flag_stop: 1'b0, en_soft: 1'b1, need_gie: 1'b1};
      SRC_MAGIC:  d = '{flag_soft: 1'b1, flag_stop: 1'b1, en_soft: 1'b1, need_gie: 1'b1};
      default:    d = '{flag_soft: 1'b0, flag_stop: 1'b0, en_soft: 1'b0, need_gie: 1'b0};
    endcase
    return d;
  endfunction

  function automatic logic [NSRC-1:0] gie_mask();
    logic [NSRC-1:0] m;
    for (int i = 0; i < NSRC; i++) m[i] = src_domain(i).need_gie;
    return m;
  endfunction

  // Interrupt request: bypass sources always count, gated ones only with gie.
  function automatic logic irq_request(input logic [NSRC-1:0] pend,
                                       input logic gie);
    return |(pend & ~gie_mask()) | (gie & |(pend & gie_mask()));
  endfunction
endpackage

// File: rtl/irqc_wdec.sv
module irqc_wdec
  import irqc_pkg::*;
(
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [NSRC-1:0]  flag_w1c,
  output logic [NSRC-1:0]  en_stb,
  output logic [NSRC-1:0]  en_val
);
  for (genvar i = 0; i < NSRC; i++) begin : g_dec
    assign flag_w1c[i] = wr_en & wr_data[2*i];
    assign en_stb[i]   = wr_en;
    assign en_val[i]   = wr_data[2*i+1];
  end
endmodule

// File: rtl/irqc_src_cell.sv
module irqc_src_cell #(
  parameter bit FLAG_SOFT = 1'b0,
  parameter bit FLAG_STOP = 1'b0,
  parameter bit EN_SOFT   = 1'b0
) (
  input  logic clk,
  input  logic hard_rst_n,
  input  logic soft_rst,
  input  logic stop_cmd,
  input  logic ev,
  input  logic w1c,
  input  logic en_stb,
  input  logic en_val,
  output logic flag,
  output logic en,
  output logic pend
);
  logic flag_kill;
  logic en_kill;

  assign flag_kill = (FLAG_SOFT && soft_rst) || (FLAG_STOP && stop_cmd);
  assign en_kill   = EN_SOFT && soft_rst;
  assign pend      = flag & en;

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n)    flag <= 1'b0;
    else if (flag_kill) flag <= 1'b0;
    else if (ev)        flag <= 1'b1;
    else if (w1c)       flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n)  en <= 1'b0;
    else if (en_kill) en <= 1'b0;
    else if (en_stb)  en <= en_val;
  end

  // R1
  ev_sets_flag_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (ev && !flag_kill) |=> flag);
  // R2
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (w1c && !ev) |=> !flag);
  // R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (!w1c && !ev && !flag_kill) |=> (flag == $past(flag)));
  // R3
  en_load_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (en_stb && !en_kill) |=> (en == $past(en_val)));

  if (FLAG_SOFT) begin : g_soft_flag
    // R5
    soft_flag_clr_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
      soft_rst |=> !flag);
  end else begin : g_keep_flag
    // R5
    soft_flag_keep_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
      (soft_rst && !ev && !w1c && !(FLAG_STOP && stop_cmd)) |=> (flag == $past(flag)));
  end

  if (FLAG_STOP) begin : g_stop_flag
    // R6
    stop_flag_clr_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
      stop_cmd |=> !flag);
  end
endmodule

// File: rtl/irqc_gate.sv
module irqc_gate
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            hard_rst_n,
  input  logic [NSRC-1:0] flag,
  input  logic [NSRC-1:0] en,
  input  logic            gie,
  output logic            pend_any,
  output logic            irq_n
);
  logic [NSRC-1:0] pend;

  assign pend     = flag & en;
  assign pend_any = |pend;
  assign irq_n    = ~irq_request(pend, gie);

  // R7
  wake_bypass_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (flag[SRC_WAKE] && en[SRC_WAKE]) |-> !irq_n);
  // R7
  defer_bypass_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (flag[SRC_DEFER] && en[SRC_DEFER]) |-> !irq_n);
  // R8
  gie_block_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (!gie && !(flag[SRC_WAKE] && en[SRC_WAKE]) && !(flag[SRC_DEFER] && en[SRC_DEFER]))
      |-> irq_n);
  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    !pend_any |-> irq_n);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             hard_rst_n,
  input  logic             soft_rst,
  input  logic             stop_cmd,
  input  logic [NSRC-1:0]  ev_pulse,
  input  logic             global_ie,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_n
);
  logic [NSRC-1:0] flag_w1c, en_stb, en_val;
  logic [NSRC-1:0] flag, en, pend;
  logic            pend_any;

  irqc_wdec u_wdec (
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .flag_w1c (flag_w1c),
    .en_stb   (en_stb),
    .en_val   (en_val)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam dom_t D = src_domain(i);
    irqc_src_cell #(
      .FLAG_SOFT (D.flag_soft),
      .FLAG_STOP (D.flag_stop),
      .EN_SOFT   (D.en_soft)
    ) u_cell (
      .clk        (clk),
      .hard_rst_n (hard_rst_n),
      .soft_rst   (soft_rst),
      .stop_cmd   (stop_cmd),
      .ev         (ev_pulse[i]),
      .w1c        (flag_w1c[i]),
      .en_stb     (en_stb[i]),
      .en_val     (en_val[i]),
      .flag       (flag[i]),
      .en         (en[i]),
      .pend       (pend[i])
    );
    assign rd_data[2*i]   = flag[i];
    assign rd_data[2*i+1] = en[i];
  end

  irqc_gate u_gate (
    .clk        (clk),
    .hard_rst_n (hard_rst_n),
    .flag       (flag),
    .en         (en),
    .gie        (global_ie),
    .pend_any   (pend_any),
    .irq_n      (irq_n)
  );

  assign rd_data[REG_W-1] = pend_any;

  // R9
  summary_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    rd_data[REG_W-1] == (pend != '0));
  // R6
  stop_en_keep_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (stop_cmd && !soft_rst && !wr_en) |=> (en == $past(en)));
endmodule

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
  logic       clk = 1'b0;
  logic       hard_rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       stop_cmd = 1'b0;
  logic [3:0] ev_pulse = '0;
  logic       global_ie = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic       irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irqc_top u_irqc_top (
    .clk        (clk),
    .hard_rst_n (hard_rst_n),
    .soft_rst   (soft_rst),
    .stop_cmd   (stop_cmd),
    .ev_pulse   (ev_pulse),
    .global_ie  (global_ie),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .irq_n      (irq_n)
  );

  function automatic logic [8:0] model_reg(input logic [3:0] f, input logic [3:0] e);
    logic [8:0] r;
    for (int i = 0; i < 4; i++) begin
      r[2*i]   = f[i];
      r[2*i+1] = e[i];
    end
    r[8] = (f & e) != 4'd0;
    return r;
  endfunction

  function automatic logic model_irq_n(input logic [3:0] f, input logic [3:0] e, input logic g);
    logic [3:0] p;
    p = f & e;
    return !(p[1] || p[2] || (g && (p[0] || p[3])));
  endfunction

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    ev_pulse = '0;
    wr_en    = 1'b0;
    wr_data  = '0;
    soft_rst = 1'b0;
    stop_cmd = 1'b0;
  endtask

  task automatic do_hard_reset();
    hard_rst_n = 1'b0;
    @(negedge clk);
    hard_rst_n = 1'b1;
  endtask

  // Enables loaded via odd bits; flags then raised by events.
  task automatic load(input logic [3:0] f, input logic [3:0] e);
    wr_en   = 1'b1;
    wr_data = model_reg(4'd0, e) & 9'h0AA;
    step();
    ev_pulse = f;
    step();
  endtask

  initial begin
    // R4: reset state
    @(negedge clk);
    check("R4 reset reg", rd_data, 9'h000);
    check("R4 reset irq", {8'd0, irq_n}, 9'h001);
    hard_rst_n = 1'b1;

    // R1 R7 R8 R9 R3: sweep all flag, enable and gie combinations
    for (int f = 0; f < 16; f++) begin
      for (int e = 0; e < 16; e++) begin
        do_hard_reset();
        global_ie = 1'b0;
        load(f[3:0], e[3:0]);
        check("R1 R3 R9 sweep reg", rd_data, model_reg(f[3:0], e[3:0]));
        check("R7 R8 sweep irq gie0", {8'd0, irq_n}, {8'd0, model_irq_n(f[3:0], e[3:0], 1'b0)});
        global_ie = 1'b1;
        #1;
        check("R7 R8 sweep irq gie1", {8'd0, irq_n}, {8'd0, model_irq_n(f[3:0], e[3:0], 1'b1)});
      end
    end

    // R2: write-one clears, write-zero keeps
    do_hard_reset();
    load(4'hF, 4'hF);
    wr_en = 1'b1;
    wr_data = 9'h0AA | 9'h001;
    step();
    check("R2 w1c syserr", rd_data, model_reg(4'hE, 4'hF));
    wr_en = 1'b1;
    wr_data = 9'h0AA;
    step();
    check("R2 write zero keeps", rd_data, model_reg(4'hE, 4'hF));

    // R1: event wins over same-cycle w1c
    wr_en = 1'b1;
    wr_data = 9'h0AA | 9'h004;
    ev_pulse = 4'b0010;
    step();
    check("R1 set beats w1c", rd_data, model_reg(4'hE, 4'hF));

    // R3: enable write pattern
    wr_en = 1'b1;
    wr_data = model_reg(4'd0, 4'b0101) & 9'h0AA;
    step();
    check("R3 enable load", rd_data, model_reg(4'hE, 4'b0101));

    // R5: soft reset domains
    do_hard_reset();
    load(4'hF, 4'hF);
    soft_rst = 1'b1;
    step();
    check("R5 soft reset", rd_data, model_reg(4'b0110, 4'b0110));

    // R6: stop clears magic flag only
    do_hard_reset();
    load(4'hF, 4'hF);
    stop_cmd = 1'b1;
    step();
    check("R6 stop", rd_data, model_reg(4'b0111, 4'hF));

    // R10: soft reset with events on syserr and wake
    do_hard_reset();
    load(4'd0, 4'hF);
    soft_rst = 1'b1;
    ev_pulse = 4'b0011;
    step();
    check("R10 soft vs event", rd_data, model_reg(4'b0010, 4'b0110));

    // R10: stop with magic event
    do_hard_reset();
    load(4'd0, 4'hF);
    stop_cmd = 1'b1;
    ev_pulse = 4'b1000;
    step();
    check("R10 stop vs event", rd_data, model_reg(4'd0, 4'hF));

    // R7: wake interrupt survives soft reset with gie low
    do_hard_reset();
    global_ie = 1'b0;
    load(4'b0010, 4'b0010);
    soft_rst = 1'b1;
    step();
    check("R7 wake after soft", {8'd0, irq_n}, 9'h000);

    // R4: hard reset mid-run
    hard_rst_n = 1'b0;
    #1;
    check("R4 async clear", rd_data, 9'h000);
    hard_rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule